// File: doc/BRIEF.md
# Instruction Exception Classifier with Delay-Slot Tracking

This block sits next to an in-order instruction decoder and, for every issued instruction, decides which exception class (if any) that instruction raises. The decoder presents one instruction per cycle as a set of flags: a valid qualifier, an undefined-opcode marker, a trap marker with an 8-bit vector number, a delayed-branch marker, a PC-write marker, a floating-point-operation marker and the two floating-point fault flags (invalid operation, divide by zero).

The classifier keeps one bit of state that says whether the instruction now being issued sits in the slot directly after a delayed branch. That context changes the outcome. A bad opcode is a slot fault inside the slot and a general illegal fault outside it. Any legal instruction that alters the PC is also a slot fault when it sits in the slot. The result is a registered one-hot cause, a vector number and a one-cycle raise strobe. All three appear on the clock edge after the instruction is issued. Fetching the vector and flushing the pipeline are left to the surrounding logic.

Top module: `exc_classifier`

## Requirements
- R1: After reset `o_raise` is 0, `o_cause` is 4'b0000, `o_vector` is 0 and the instruction that follows is treated as outside a delay slot.
- R2: A valid instruction with `i_undef` set while in a delay slot raises cause 4'b0001 (slot fault) with vector `VEC_SLOT` (default 8'd6).
- R3: A valid instruction with `i_undef` set outside a delay slot raises cause 4'b0010 (general illegal) with vector `VEC_GEN` (default 8'd4).
- R4: A valid instruction with `i_pc_write` or `i_dly_branch` set while in a delay slot raises cause 4'b0001 with vector `VEC_SLOT`.
- R5: A valid instruction with `i_trap` set outside a delay slot raises cause 4'b0100 with `o_vector` equal to `i_trap_vec`.
- R6: A valid instruction with `i_fp_op` set and either `i_fp_inval` or `i_fp_divz` set raises cause 4'b1000 with vector `VEC_FP` (default 8'd9). The fault flags have no effect when `i_fp_op` is low.
- R7: When several classes apply, exactly one is reported. The order from highest is: slot fault (bit 0), general illegal (bit 1), trap (bit 2), floating point (bit 3).
- R8: The delay-slot flag is set by a valid delayed branch that raises nothing. It is cleared by the next valid instruction, by any raise, and by reset. Cycles with `i_valid` low leave it unchanged.
- R9: A cycle with `i_valid` low never raises, whatever the other inputs.
- R10: `o_raise` is high for exactly the one cycle after each raising instruction. While `o_raise` is low, `o_cause` and `o_vector` keep their last raised values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| i_valid | input | 1 | An instruction is issued this cycle |
| i_undef | input | 1 | Opcode is undefined |
| i_trap | input | 1 | Instruction is a trap |
| i_trap_vec | input | 8 | Vector number carried by the trap |
| i_dly_branch | input | 1 | Instruction is a delayed branch |
| i_pc_write | input | 1 | Instruction changes the PC |
| i_fp_op | input | 1 | Instruction is a floating-point operation that can fault |
| i_fp_inval | input | 1 | Floating-point invalid-operation flag |
| i_fp_divz | input | 1 | Floating-point divide-by-zero flag |
| o_raise | output | 1 | One-cycle exception strobe |
| o_cause | output | 4 | One-hot cause, held between raises |
| o_vector | output | 8 | Vector number, held between raises |

## Verification
The hardest case to reach is an instruction in a delay slot. The slot exists only for one instruction, right after a delayed branch that raised nothing, and idle cycles in between must leave it open. The bench sends every one of the 128 flag combinations twice: once after a plain instruction and once straight after a clean delayed branch. A further sequence inserts idle cycles, with fault flags high, between the branch and its slot instruction. A bench-side model of the slot bit, built from the requirements, predicts each outcome.

// File: rtl/exc_cls_pkg.sv
package exc_cls_pkg;

    localparam int NCAUSE = 4;
    localparam int VEC_W  = 8;

    // cause bit positions, lowest index has highest priority
    localparam int C_SLOT = 0;
    localparam int C_GEN  = 1;
    localparam int C_TRAP = 2;
    localparam int C_FP   = 3;

    typedef struct packed {
        logic              in_slot;
        logic              raise;
        logic [NCAUSE-1:0] cause;
        logic [VEC_W-1:0]  vector;
    } cls_state_t;

endpackage

// File: rtl/exc_cond_eval.sv
module exc_cond_eval
    import exc_cls_pkg::*;
(
    input  logic              in_slot,
    input  logic              undef,
    input  logic              trap,
    input  logic              dly_branch,
    input  logic              pc_write,
    input  logic              fp_op,
    input  logic              fp_inval,
    input  logic              fp_divz,
    output logic [NCAUSE-1:0] hit
);

    always_comb begin
        hit         = '0;
        hit[C_SLOT] = in_slot & (undef | pc_write | dly_branch);
        hit[C_GEN]  = ~in_slot & undef;
        hit[C_TRAP] = trap;
        hit[C_FP]   = fp_op & (fp_inval | fp_divz);
    end

endmodule

// File: rtl/exc_prio_pick.sv
module exc_prio_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);

    for (genvar i = 0; i < N; i++) begin : g_pick
        if (i == 0) begin : g_first
            assign grant[i] = req[i];
        end else begin : g_rest
            assign grant[i] = req[i] & ~(|req[i-1:0]);
        end
    end

endmodule

// File: rtl/exc_classifier.sv
module exc_classifier
    import exc_cls_pkg::*;
#(
    parameter logic [VEC_W-1:0] VEC_SLOT = 8'd6,
    parameter logic [VEC_W-1:0] VEC_GEN  = 8'd4,
    parameter logic [VEC_W-1:0] VEC_FP   = 8'd9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             i_valid,
    input  logic             i_undef,
    input  logic             i_trap,
    input  logic [7:0]       i_trap_vec,
    input  logic             i_dly_branch,
    input  logic             i_pc_write,
    input  logic             i_fp_op,
    input  logic             i_fp_inval,
    input  logic             i_fp_divz,
    output logic             o_raise,
    output logic [3:0]       o_cause,
    output logic [7:0]       o_vector
);

    cls_state_t        st_d, st_q;
    logic [NCAUSE-1:0] hit;
    logic [NCAUSE-1:0] grant;
    logic [VEC_W-1:0]  vec_sel;
    logic              any_hit;

    exc_cond_eval u_eval (
        .in_slot    (st_q.in_slot),
        .undef      (i_undef),
        .trap       (i_trap),
        .dly_branch (i_dly_branch),
        .pc_write   (i_pc_write),
        .fp_op      (i_fp_op),
        .fp_inval   (i_fp_inval),
        .fp_divz    (i_fp_divz),
        .hit        (hit)
    );

    exc_prio_pick #(.N(NCAUSE)) u_pick (
        .req   (hit),
        .grant (grant)
    );

    always_comb begin
        vec_sel = '0;
        if (grant[C_SLOT])      vec_sel = VEC_SLOT;
        else if (grant[C_GEN])  vec_sel = VEC_GEN;
        else if (grant[C_TRAP]) vec_sel = i_trap_vec;
        else if (grant[C_FP])   vec_sel = VEC_FP;
    end

    assign any_hit = |hit;

    always_comb begin
        st_d       = st_q;
        st_d.raise = 1'b0;
        if (i_valid) begin
            if (any_hit) begin
                st_d.raise   = 1'b1;
                st_d.cause   = grant;
                st_d.vector  = vec_sel;
                st_d.in_slot = 1'b0;
            end else begin
                st_d.in_slot = i_dly_branch;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign o_raise  = st_q.raise;
    assign o_cause  = st_q.cause;
    assign o_vector = st_q.vector;

endmodule

// File: rtl/exc_classifier_chk.sv
module exc_classifier_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       i_valid,
    input logic       i_undef,
    input logic       i_trap,
    input logic [7:0] i_trap_vec,
    input logic       o_raise,
    input logic [3:0] o_cause,
    input logic [7:0] o_vector
);

    // R7: a raise always reports exactly one cause
    a_r7_onehot_cause: assert property (@(posedge clk) disable iff (!rst_n)
        o_raise |-> $onehot(o_cause));

    // R9: an idle cycle never raises
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!i_valid) |-> !o_raise);

    // R10: cause and vector hold while no raise
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!o_raise && $past(rst_n)) |-> ($stable(o_cause) && $stable(o_vector)));

    // R2 R3: an undefined opcode always raises an illegal class
    a_r3_undef_raises: assert property (@(posedge clk) disable iff (!rst_n)
        $past(i_valid && i_undef && rst_n) |-> (o_raise && (o_cause[0] || o_cause[1])));

    // R5: a trap always raises; when it wins, the vector is the trap's own
    a_r5_trap_raises: assert property (@(posedge clk) disable iff (!rst_n)
        $past(i_valid && i_trap && rst_n) |-> o_raise);

    a_r5_trap_vector: assert property (@(posedge clk) disable iff (!rst_n)
        (o_raise && o_cause[2]) |-> (o_vector == $past(i_trap_vec)));

endmodule

bind exc_classifier exc_classifier_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .i_valid    (i_valid),
    .i_undef    (i_undef),
    .i_trap     (i_trap),
    .i_trap_vec (i_trap_vec),
    .o_raise    (o_raise),
    .o_cause    (o_cause),
    .o_vector   (o_vector)
);

// File: tb/exc_classifier_test.sv
module exc_classifier_test;

    localparam logic [7:0] V_SLOT = 8'd6;
    localparam logic [7:0] V_GEN  = 8'd4;
    localparam logic [7:0] V_FP   = 8'd9;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       i_valid = 1'b0, i_undef = 1'b0, i_trap = 1'b0;
    logic [7:0] i_trap_vec = 8'd0;
    logic       i_dly_branch = 1'b0, i_pc_write = 1'b0, i_fp_op = 1'b0;
    logic       i_fp_inval = 1'b0, i_fp_divz = 1'b0;
    logic       o_raise;
    logic [3:0] o_cause;
    logic [7:0] o_vector;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // bench-side expectation state
    bit         m_slot = 1'b0;
    logic [3:0] m_cause = 4'd0;
    logic [7:0] m_vec = 8'd0;

    always #4 clk = ~clk;

    exc_classifier uut (
        .clk(clk), .rst_n(rst_n), .i_valid(i_valid), .i_undef(i_undef),
        .i_trap(i_trap), .i_trap_vec(i_trap_vec), .i_dly_branch(i_dly_branch),
        .i_pc_write(i_pc_write), .i_fp_op(i_fp_op), .i_fp_inval(i_fp_inval),
        .i_fp_divz(i_fp_divz), .o_raise(o_raise), .o_cause(o_cause),
        .o_vector(o_vector)
    );

    task automatic check(input string rq, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // f: [0]undef [1]trap [2]dly_branch [3]pc_write [4]fp_op [5]fp_inval [6]fp_divz
    task automatic issue(input bit v, input logic [6:0] f, input logic [7:0] vec);
        bit h_slot, h_gen, h_trp, h_fp, rz;
        logic [3:0] ec;
        logic [7:0] ev;
        string rq;
        @(negedge clk);
        i_valid = v; i_undef = f[0]; i_trap = f[1]; i_dly_branch = f[2];
        i_pc_write = f[3]; i_fp_op = f[4]; i_fp_inval = f[5]; i_fp_divz = f[6];
        i_trap_vec = vec;
        h_slot = m_slot && (f[0] || f[3] || f[2]);
        h_gen  = !m_slot && f[0];
        h_trp  = f[1];
        h_fp   = f[4] && (f[5] || f[6]);
        rz = v && (h_slot || h_gen || h_trp || h_fp);
        ec = m_cause; ev = m_vec;
        if (rz) begin
            if (h_slot)     begin ec = 4'b0001; ev = V_SLOT; end
            else if (h_gen) begin ec = 4'b0010; ev = V_GEN;  end
            else if (h_trp) begin ec = 4'b0100; ev = vec;    end
            else            begin ec = 4'b1000; ev = V_FP;   end
        end
        if (!v)                                         rq = "R9";
        else if ((h_slot + h_gen + h_trp + h_fp) > 1)   rq = "R7";
        else if (h_slot && f[0])                        rq = "R2";
        else if (h_slot)                                rq = "R4";
        else if (h_gen)                                 rq = "R3";
        else if (h_trp)                                 rq = "R5";
        else if (h_fp || f[5] || f[6])                  rq = "R6";
        else if (m_slot || f[2])                        rq = "R8";
        else                                            rq = "R10";
        @(posedge clk);
        #1;
        check(rq, {15'd0, o_raise}, {15'd0, rz});
        check(rq, {4'd0, o_cause, o_vector}, {4'd0, ec, ev});
        m_cause = ec; m_vec = ev;
        if (rz)     m_slot = 1'b0;
        else if (v) m_slot = f[2];
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check("R1", {7'd0, o_raise, o_cause, 4'd0}, 16'd0);
        check("R1", {8'd0, o_vector}, 16'd0);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: undefined opcode right after reset is general illegal
        issue(1'b1, 7'b0000001, 8'd0);

        // sweep every flag combination outside and inside a slot
        for (int c = 0; c < 128; c++) begin
            issue(1'b1, 7'd0, 8'd0);                // plain: clears slot
            issue(1'b1, c[6:0], 8'(c + 8'd17));
            issue(1'b1, 7'd0, 8'd0);
            issue(1'b1, 7'b0000100, 8'd0);          // clean delayed branch: R8
            issue(1'b1, c[6:0], 8'(8'd200 - c));
        end

        // R8/R9: idle cycles with fault flags keep the slot open
        issue(1'b1, 7'd0, 8'd0);
        issue(1'b1, 7'b0000100, 8'd0);
        issue(1'b0, 7'b1111111, 8'd55);
        issue(1'b0, 7'b0000001, 8'd56);
        issue(1'b1, 7'b0000001, 8'd0);              // R2 in slot after idles
        // R8: slot closes after one instruction
        issue(1'b1, 7'b0000100, 8'd0);
        issue(1'b1, 7'd0, 8'd0);
        issue(1'b1, 7'b0001000, 8'd0);              // PC write, no slot: nothing
        issue(1'b1, 7'b0000001, 8'd0);              // R3
        // R10: back-to-back raises and holding
        issue(1'b1, 7'b0000010, 8'd77);
        issue(1'b1, 7'b0110000, 8'd0);
        issue(1'b1, 7'd0, 8'd0);
        issue(1'b0, 7'd0, 8'd0);

        // R1: reset mid-stream clears outputs and slot
        issue(1'b1, 7'b0000100, 8'd0);
        @(negedge clk);
        rst_n = 1'b0; i_valid = 1'b0;
        @(posedge clk);
        #1;
        check("R1", {7'd0, o_raise, o_cause, 4'd0}, 16'd0);
        @(negedge clk);
        rst_n = 1'b1;
        m_slot = 1'b0; m_cause = 4'd0; m_vec = 8'd0;
        issue(1'b1, 7'b0000001, 8'd0);              // general, not slot
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule